// File: doc/BRIEF.md
# Pipelined Tagged Bitonic Sorter

This block sorts a fixed-size list of measurements in a single pass through a bitonic compare-exchange network, with a register bank after every stage. Each list element pairs an unsigned voltage key with a signed tag that names the source module. The tag rides along with its key through every exchange. The sorted list therefore says both the order of the voltages and which module each voltage came from.

The network is built for a worst-case list length `M`, a power of two. When fewer modules are live, the caller fills the spare slots with dummy entries: voltage zero and tag minus one. These dummies settle at the low end of the output. Every stage is registered, so the block takes a new list on every clock. A valid flag travels alongside the data, and the sorted list appears a fixed number of cycles later. Gathering the voltages and choosing modules from the sorted list are done by neighbouring logic.

Top module: `bitonic_sorter_pipe`

## Requirements
- R1: When `out_valid` is high, output voltages are in descending order: slot 0 (bits `[VW-1:0]`) holds the largest voltage and slot `M-1` holds the smallest.
- R2: Every output slot carries the same (voltage, tag) pair that entered together, and the output list holds exactly the input pairs. Slot `i` sits at bits `[i*VW +: VW]` of the voltage bus and bits `[i*PW +: PW]` of the tag bus.
- R3: A new list may be presented on every clock. Back-to-back lists emerge back to back, in arrival order, with none lost or merged.
- R4: `out_valid` equals `in_valid` delayed by exactly `log2(M)*(log2(M)+1)/2` clocks (6 for M = 8), and gaps between lists are preserved.
- R5: Dummy entries (voltage 0, tag all ones, meaning -1) occupy the last output slots whenever every live voltage is nonzero.
- R6: A compare-exchange cell does not swap equal voltages. As a result, a list whose voltages are all equal comes out with its tags in input order.
- R7: A synchronous active-high reset clears every valid flag. `out_valid` is low on the cycle after reset and stays low until a list presented after reset has crossed the pipeline.
- R8: Data presented while `in_valid` is low never produces a high `out_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input list is valid this cycle |
| in_volt | input | M*VW | Input voltages, slot i at bits [i*VW +: VW] |
| in_pos | input | M*PW | Input tags (two's complement), slot i at [i*PW +: PW] |
| out_valid | output | 1 | Sorted list is valid this cycle |
| out_volt | output | M*VW | Sorted voltages, highest in slot 0 |
| out_pos | output | M*PW | Tags matching the sorted voltages |

## Verification
The bench drives several kinds of lists:
- Random lists with distinct voltages pin every tag to a single slot, which exposes any exchange that moves a key without its tag.
- Ascending and descending inputs stress the network's worst-case routing.
- Lists with many repeated voltages, checked as a multiset of pairs, catch lost or duplicated entries.
- An all-equal list separates a strict comparison from a non-strict one.
- Short lists padded with dummies show that the dummies sink to the bottom.

Streams with gaps, invalid data carrying garbage, and a reset in the middle of a stream distinguish correct valid-flag timing from off-by-one delays and from valid flags that leak through.

// File: rtl/bitonic_pkg.sv
package bitonic_pkg;
  // number of registered compare-exchange stages for a 2**lg element list
  function automatic int stage_count(input int lg);
    return lg * (lg + 1) / 2;
  endfunction
endpackage

// File: rtl/bitonic_cas.sv
module bitonic_cas #(
  parameter int VW   = 12,
  parameter int PW   = 6,
  parameter bit DESC = 1'b1
) (
  input  logic [VW-1:0] a_v,
  input  logic [PW-1:0] a_p,
  input  logic [VW-1:0] b_v,
  input  logic [PW-1:0] b_p,
  output logic [VW-1:0] x_v,
  output logic [PW-1:0] x_p,
  output logic [VW-1:0] y_v,
  output logic [PW-1:0] y_p
);
  logic swap;

  // strict comparison: equal keys stay on their wires (R6)
  assign swap = DESC ? (a_v < b_v) : (a_v > b_v);

  assign x_v = swap ? b_v : a_v;
  assign y_v = swap ? a_v : b_v;
  assign x_p = swap ? b_p : a_p;
  assign y_p = swap ? a_p : b_p;

  always_comb begin
    // R1: cell output respects its direction
    assert_cas_order_R1: assert (DESC ? (x_v >= y_v) : (x_v <= y_v));
    // R2: the pair leaving each side is a pair that entered
    assert_cas_pair_R2: assert (((x_v == a_v) && (x_p == a_p) && (y_v == b_v) && (y_p == b_p)) ||
                                ((x_v == b_v) && (x_p == b_p) && (y_v == a_v) && (y_p == a_p)));
  end
endmodule

// File: rtl/bitonic_stage.sv
module bitonic_stage #(
  parameter int M    = 8,
  parameter int VW   = 12,
  parameter int PW   = 6,
  parameter int BLK  = 2,
  parameter int DIST = 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 vld_i,
  input  logic [M-1:0][VW-1:0] v_i,
  input  logic [M-1:0][PW-1:0] p_i,
  output logic                 vld_o,
  output logic [M-1:0][VW-1:0] v_o,
  output logic [M-1:0][PW-1:0] p_o
);
  logic [M-1:0][VW-1:0] v_c;
  logic [M-1:0][PW-1:0] p_c;

  for (genvar i = 0; i < M; i++) begin : g_wire
    if ((i & DIST) == 0) begin : g_cell
      localparam bit DIR_DESC = ((i & BLK) == 0);
      bitonic_cas #(.VW(VW), .PW(PW), .DESC(DIR_DESC)) u_cas (
        .a_v(v_i[i]),        .a_p(p_i[i]),
        .b_v(v_i[i + DIST]), .b_p(p_i[i + DIST]),
        .x_v(v_c[i]),        .x_p(p_c[i]),
        .y_v(v_c[i + DIST]), .y_p(p_c[i + DIST])
      );
    end
  end

  always_ff @(posedge clk) begin
    if (rst) vld_o <= 1'b0;
    else     vld_o <= vld_i;
  end

  always_ff @(posedge clk) begin
    v_o <= v_c;
    p_o <= p_c;
  end

  // R4: the valid flag moves exactly one stage per clock
  assert_valid_step_R4: assert property (@(posedge clk) disable iff (rst) vld_i |=> vld_o);
  // R8: an idle slot stays idle
  assert_idle_step_R8: assert property (@(posedge clk) disable iff (rst) !vld_i |=> !vld_o);
endmodule

// File: rtl/bitonic_sorter_pipe.sv
module bitonic_sorter_pipe
  import bitonic_pkg::*;
#(
  parameter int M  = 8,
  parameter int VW = 12,
  parameter int PW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [M*VW-1:0] in_volt,
  input  logic [M*PW-1:0] in_pos,
  output logic          out_valid,
  output logic [M*VW-1:0] out_volt,
  output logic [M*PW-1:0] out_pos
);
  localparam int LG   = $clog2(M);
  localparam int NSTG = stage_count(LG);

  logic [M-1:0][VW-1:0] vs [NSTG+1];
  logic [M-1:0][PW-1:0] ps [NSTG+1];
  logic                 vl [NSTG+1];

  assign vs[0] = in_volt;
  assign ps[0] = in_pos;
  assign vl[0] = in_valid;

  // phase p merges blocks of 2**p; step q compares at distance 2**(p-1-q)
  for (genvar p = 1; p <= LG; p++) begin : g_phase
    for (genvar q = 0; q < p; q++) begin : g_step
      localparam int S = p * (p - 1) / 2 + q;
      bitonic_stage #(
        .M(M), .VW(VW), .PW(PW), .BLK(1 << p), .DIST(1 << (p - 1 - q))
      ) u_stg (
        .clk(clk), .rst(rst),
        .vld_i(vl[S]),   .v_i(vs[S]),   .p_i(ps[S]),
        .vld_o(vl[S+1]), .v_o(vs[S+1]), .p_o(ps[S+1])
      );
    end
  end

  assign out_valid = vl[NSTG];
  assign out_volt  = vs[NSTG];
  assign out_pos   = ps[NSTG];

  for (genvar i = 0; i < M - 1; i++) begin : g_chk
    // R1: neighbouring output slots are in descending order
    assert_out_sorted_R1: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> (vs[NSTG][i] >= vs[NSTG][i+1]));
  end

  // R7: reset empties the pipeline
  assert_reset_clear_R7: assert property (@(posedge clk) rst |=> !out_valid);
endmodule

// File: tb/bitonic_sorter_pipe_tb.sv
module bitonic_sorter_pipe_tb;
  localparam int M   = 8;
  localparam int VW  = 12;
  localparam int PW  = 6;
  localparam int LG  = $clog2(M);
  localparam int LAT = LG * (LG + 1) / 2;
  localparam int PMASK = (1 << PW) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [M*VW-1:0] in_volt = '0;
  logic [M*PW-1:0] in_pos = '0;
  logic out_valid;
  logic [M*VW-1:0] out_volt;
  logic [M*PW-1:0] out_pos;

  int n_chk = 0;
  int n_fail = 0;
  bit model_on = 1'b0;

  always #4 clk = ~clk;

  bitonic_sorter_pipe #(.M(M), .VW(VW), .PW(PW)) u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_volt(in_volt), .in_pos(in_pos),
    .out_valid(out_valid), .out_volt(out_volt), .out_pos(out_pos)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // reference model: a queue of lists per pipeline slot
  bit mvld [LAT];
  bit msame[LAT];
  int mraw_v[LAT][M];
  int mraw_p[LAT][M];
  int msrt_v[LAT][M];
  int msrt_p[LAT][M];

  always @(posedge clk) begin
    for (int s = LAT - 1; s > 0; s--) begin
      mvld[s] = mvld[s-1]; msame[s] = msame[s-1];
      for (int i = 0; i < M; i++) begin
        mraw_v[s][i] = mraw_v[s-1][i]; mraw_p[s][i] = mraw_p[s-1][i];
        msrt_v[s][i] = msrt_v[s-1][i]; msrt_p[s][i] = msrt_p[s-1][i];
      end
    end
    mvld[0] = in_valid;
    msame[0] = 1'b1;
    for (int i = 0; i < M; i++) begin
      mraw_v[0][i] = int'(in_volt[i*VW +: VW]);
      mraw_p[0][i] = int'(in_pos[i*PW +: PW]);
      if (mraw_v[0][i] != mraw_v[0][0]) msame[0] = 1'b0;
    end
    // stable insertion sort, descending
    for (int i = 0; i < M; i++) begin
      int j;
      j = i;
      msrt_v[0][i] = mraw_v[0][i]; msrt_p[0][i] = mraw_p[0][i];
      while (j > 0 && msrt_v[0][j-1] < msrt_v[0][j]) begin
        int tv, tp;
        tv = msrt_v[0][j]; tp = msrt_p[0][j];
        msrt_v[0][j] = msrt_v[0][j-1]; msrt_p[0][j] = msrt_p[0][j-1];
        msrt_v[0][j-1] = tv; msrt_p[0][j-1] = tp;
        j--;
      end
    end
    if (rst) for (int s = 0; s < LAT; s++) mvld[s] = 1'b0;
  end

  always @(negedge clk) begin
    if (model_on) begin
      check(out_valid == mvld[LAT-1], "R4 R8 R3 out_valid", int'(out_valid), int'(mvld[LAT-1]));
      if (mvld[LAT-1] && out_valid) begin
        for (int i = 0; i < M; i++) begin
          int ov, op, cin, cout;
          ov = int'(out_volt[i*VW +: VW]);
          op = int'(out_pos[i*PW +: PW]);
          check(ov == msrt_v[LAT-1][i], "R1 R3 voltage order", ov, msrt_v[LAT-1][i]);
          cin = 0; cout = 0;
          for (int k = 0; k < M; k++) begin
            if (mraw_v[LAT-1][k] == ov && mraw_p[LAT-1][k] == op) cin++;
            if (int'(out_volt[k*VW +: VW]) == ov && int'(out_pos[k*PW +: PW]) == op) cout++;
          end
          check(cin == cout, (msrt_p[LAT-1][i] == PMASK && msrt_v[LAT-1][i] == 0) ?
                "R5 dummy pair" : "R2 pair kept", cout, cin);
          if (msame[LAT-1])
            check(op == msrt_p[LAT-1][i], "R6 equal keys keep order", op, msrt_p[LAT-1][i]);
          else if ((i == 0 || msrt_v[LAT-1][i-1] != msrt_v[LAT-1][i]) &&
                   (i == M-1 || msrt_v[LAT-1][i+1] != msrt_v[LAT-1][i]))
            check(op == msrt_p[LAT-1][i], "R2 tag follows voltage", op, msrt_p[LAT-1][i]);
        end
      end
    end
  end

  // kind: 0 distinct random, 1 ascending, 2 descending, 3 repeats, 4 all equal
  task automatic send(input int kind, input int live);
    for (int i = 0; i < M; i++) begin
      int v, p;
      p = i;
      case (kind)
        0: v = ((int'($urandom) & 255) << 3 | i) + 1;
        1: v = 10 * i + 5;
        2: v = 1000 - 10 * i;
        3: v = (int'($urandom) % 3) + 1;
        default: v = 77;
      endcase
      if (i >= live) begin v = 0; p = -1; end
      in_volt[i*VW +: VW] = VW'(v);
      in_pos[i*PW +: PW]  = PW'(p);
    end
    in_valid = 1'b1;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      in_valid = 1'b0;
      in_volt = M*VW'($urandom);
      in_pos  = M*PW'($urandom);
      @(negedge clk);
    end
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R7 reset state", int'(out_valid), 0);
    rst = 1'b0;
    model_on = 1'b1;
    idle(2);
    for (int k = 0; k < 24; k++) send(0, M);   // R3 back-to-back
    send(1, M); send(2, M); send(1, M);
    idle(LAT + 1);
    for (int k = 0; k < 10; k++) send(3, M);
    send(4, M); send(4, 3);                    // R6
    send(0, 3); send(0, 5); send(0, 1); send(2, 6);  // R5
    for (int k = 0; k < 12; k++) begin          // R8 gaps
      send(0, M);
      idle(k % 3);
    end
    send(0, M); send(0, M); send(0, M);
    rst = 1'b1;                                 // R7 mid-stream reset
    send(0, M);
    rst = 1'b0;
    idle(LAT + 2);
    send(3, 4);
    idle(LAT + 3);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule